// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block is a single-channel DMA engine. It moves 32-bit words between a memory port and a word-wide peripheral port. The work comes from a chain of descriptors that sit in memory. Software writes one control word, which holds the byte address of the first descriptor and a start bit. The engine then reads the whole descriptor and carries out the word moves it describes, in blocks. It writes a completion status back into the descriptor and can raise an interrupt. If the link word marks a successor, the engine moves on to it.

A chain whose last link points back to its first descriptor forms a ring. A ring runs until software writes the stop bit. A later start bit resumes the paused chain at the exact word where it halted, without reading the chain again. A control write of all zeros discards the paused context, so the next start loads a new chain.

Both ports use a request/acknowledge handshake. A request and its address and data stay stable until the acknowledge cycle. Read data is taken in that same cycle. Only one word is ever in flight.

Top module: `chain_dma`

## Requirements
- R1: After reset, no request is raised on either port, and both the interrupt pulse and the pending flag are low.
- R2: A control write decodes as follows: bit 3 is start, bit 4 is stop, and bits 31:5 are the first descriptor byte address, with the low five address bits taken as zero. Stop wins when both bits are set. A start while no chain is loaded issues twelve memory reads at consecutive word addresses from that address.
- R3: The descriptor is used in this way: word 0 is the link (bit 0 = successor valid, bits 31:2 = successor word address), word 1 is the memory byte address, word 2 is the peripheral address, word 3 is the length in words, word 4 is the block gap in words, word 5 is the block count, and word 6 is the command. Words 7 to 11 are read but not used. No data moves until all twelve words have been read.
- R4: With command bit 12 set, each word is read from memory and then written to the peripheral, for length × count words in total. The peripheral address stays fixed. The memory address rises by 4 per word, and by a further 4 × gap after each block.
- R5: With command bit 12 clear, each word is read from the peripheral address and written to memory, using the same addressing as R4.
- R6: A descriptor with a zero length or a zero count moves no data, but it still completes: it writes back its status and raises its interrupt.
- R7: After the last block, the engine writes the value 0x00000001 to byte offset 28 of the descriptor.
- R8: With command bit 1 set, `irq` pulses high for one cycle, in the cycle after the status write is acknowledged, and `irq_pending` sets at the same edge. `pend_clr` clears `irq_pending`. When a set and a clear fall in the same cycle, the set wins.
- R9: A valid link makes the engine fetch the next descriptor at the link address. A clear link returns the engine to idle after the status write. A link back to an earlier descriptor loops until stop.
- R10: After stop, no new request starts once the request in flight is acknowledged. A start with a paused chain resumes at the next word with no refetch. A start while running is ignored.
- R11: A control write of all zeros discards the loaded chain. The next start then fetches from the newly written address.
- R12: A request holds its address, direction and data until it is acknowledged. The two ports are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: start, stop, first descriptor address |
| pend_clr | input | 1 | Clears the interrupt pending flag |
| irq | output | 1 | One-cycle completion interrupt |
| irq_pending | output | 1 | Sticky completion flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Memory read data |
| pp_req | output | 1 | Peripheral request |
| pp_we | output | 1 | Peripheral request is a write |
| pp_addr | output | AW | Peripheral address |
| pp_wdata | output | 32 | Peripheral write data |
| pp_ack | input | 1 | Peripheral acknowledge; read data valid |
| pp_rdata | input | 32 | Peripheral read data |

## Verification
The same-cycle case is a descriptor completion that sets the pending flag while the clear input is also active. The bench holds `pend_clr` high for the whole of alternate random runs. Every completion therefore meets a clear in the same cycle. In every cycle where `irq` is high, `irq_pending` must read 1. Once the chain has gone quiet, the flag must read 0. In the ring test, a stop write lands while a request may still be waiting for its acknowledge, to show that the request in flight finishes and nothing new starts.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SRC,
      ST_DST,
      ST_WB
   } seq_state_e;

   // control word fields
   localparam int CTL_START_BIT = 3;
   localparam int CTL_STOP_BIT  = 4;
   localparam int CTL_ADDR_LSB  = 5;

   // command word fields
   localparam int CMD_IRQ_BIT   = 1;
   localparam int CMD_DIR_BIT   = 12;

   // descriptor word indices
   localparam int DESC_WORDS    = 12;
   localparam int W_LINK        = 0;
   localparam int W_MADDR       = 1;
   localparam int W_PADDR       = 2;
   localparam int W_LEN         = 3;
   localparam int W_GAP         = 4;
   localparam int W_CNT         = 5;
   localparam int W_CMD         = 6;
   localparam int W_STAT        = 7;

   localparam logic [31:0] STAT_DONE = 32'h0000_0001;
endpackage

// File: rtl/cdma_cmd.sv
module cdma_cmd
   import cdma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [31:0]   ctl_wdata,
   input  logic          ctx_live,
   output logic          run,
   output logic          go_new,
   output logic          flush,
   output logic [AW-1:0] first_addr
);
   logic stop_w, start_w;

   assign stop_w     = ctl_we & ctl_wdata[CTL_STOP_BIT];
   assign start_w    = ctl_we & ctl_wdata[CTL_START_BIT] & ~ctl_wdata[CTL_STOP_BIT];
   assign flush      = ctl_we & (ctl_wdata == 32'h0);
   assign go_new     = start_w & ~ctx_live;
   assign first_addr = {ctl_wdata[AW-1:CTL_ADDR_LSB], {CTL_ADDR_LSB{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n)                run <= 1'b0;
      else if (stop_w || flush)  run <= 1'b0;
      else if (start_w)          run <= 1'b1;
   end

   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[CTL_STOP_BIT]) |=> !run);  // R2
endmodule

// File: rtl/cdma_irq.sv
module cdma_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic clr,
   output logic irq,
   output logic pending
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         pending <= 1'b0;
      end else begin
         irq <= done;
         if (done)     pending <= 1'b1;
         else if (clr) pending <= 1'b0;
      end
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);  // R8
   AST_PEND_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pending);  // R8
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
   import cdma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LEN_W      = 16,
   parameter int CNT_W      = 16,
   parameter bit STEP_WORDS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          go_new,
   input  logic          flush,
   input  logic [AW-1:0] first_addr,
   output logic          ctx_live,
   output logic          desc_done,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          pp_req,
   output logic          pp_we,
   output logic [AW-1:0] pp_addr,
   output logic [31:0]   pp_wdata,
   input  logic          pp_ack,
   input  logic [31:0]   pp_rdata
);
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

   seq_state_e       st;
   logic [AW-1:0]    base, maddr, paddr, gap_b;
   logic [AW-3:0]    link_ptr;
   logic             link_ok, dir, irq_en, hold;
   logic [LEN_W-1:0] len, wcnt;
   logic [CNT_W-1:0] cnt, bcnt;
   logic [IDX_W-1:0] widx;
   logic [31:0]      dbuf, rd_word;
   logic [AW-1:0]    rd_gap;
   logic             use_mem, use_pp, go, bus_req, bus_ack, xfer, last_word, last_blk;

   generate
      if (STEP_WORDS) begin : g_gap_words
         assign rd_gap = {rd_word[AW-3:0], 2'b00};
      end else begin : g_gap_bytes
         assign rd_gap = rd_word[AW-1:0];
      end
   endgenerate

   assign use_mem = (st == ST_FETCH) || (st == ST_WB) ||
                    (st == ST_SRC && dir) || (st == ST_DST && !dir);
   assign use_pp  = (st == ST_SRC && !dir) || (st == ST_DST && dir);
   assign go      = run | hold;
   assign mem_req = go & use_mem;
   assign pp_req  = go & use_pp;
   assign bus_req = mem_req | pp_req;
   assign bus_ack = use_mem ? mem_ack : pp_ack;
   assign xfer    = bus_req & bus_ack;
   assign rd_word = use_mem ? mem_rdata : pp_rdata;

   assign mem_we    = (st == ST_WB) || (st == ST_DST);
   assign mem_wdata = (st == ST_WB) ? STAT_DONE : dbuf;
   assign pp_we     = (st == ST_DST);
   assign pp_addr   = paddr;
   assign pp_wdata  = dbuf;

   always_comb begin
      case (st)
         ST_FETCH: mem_addr = base + AW'({widx, 2'b00});
         ST_WB:    mem_addr = base + AW'(W_STAT * 4);
         default:  mem_addr = maddr;
      endcase
   end

   assign last_word = (wcnt == len - LEN_W'(1));
   assign last_blk  = (bcnt == cnt - CNT_W'(1));
   assign ctx_live  = (st != ST_IDLE);
   assign desc_done = (st == ST_WB) & xfer & irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;  hold <= 1'b0;  widx <= '0;
         base <= '0;  maddr <= '0;  paddr <= '0;  gap_b <= '0;
         link_ptr <= '0;  link_ok <= 1'b0;  dir <= 1'b0;  irq_en <= 1'b0;
         len <= '0;  cnt <= '0;  wcnt <= '0;  bcnt <= '0;  dbuf <= '0;
      end else if (flush) begin
         st   <= ST_IDLE;
         hold <= 1'b0;
      end else begin
         hold <= bus_req & ~bus_ack;
         case (st)
            ST_IDLE: if (go_new) begin
               base <= first_addr;
               widx <= '0;
               st   <= ST_FETCH;
            end
            ST_FETCH: if (xfer) begin
               case (widx)
                  IDX_W'(W_LINK):  begin
                     link_ptr <= rd_word[AW-1:2];
                     link_ok  <= rd_word[0];
                  end
                  IDX_W'(W_MADDR): maddr <= rd_word[AW-1:0];
                  IDX_W'(W_PADDR): paddr <= rd_word[AW-1:0];
                  IDX_W'(W_LEN):   len   <= rd_word[LEN_W-1:0];
                  IDX_W'(W_GAP):   gap_b <= rd_gap;
                  IDX_W'(W_CNT):   cnt   <= rd_word[CNT_W-1:0];
                  IDX_W'(W_CMD):   begin
                     dir    <= rd_word[CMD_DIR_BIT];
                     irq_en <= rd_word[CMD_IRQ_BIT];
                  end
                  default: ;
               endcase
               widx <= widx + IDX_W'(1);
               if (widx == IDX_LAST) begin
                  wcnt <= '0;
                  bcnt <= '0;
                  st   <= (len == '0 || cnt == '0) ? ST_WB : ST_SRC;
               end
            end
            ST_SRC: if (xfer) begin
               dbuf <= rd_word;
               st   <= ST_DST;
            end
            ST_DST: if (xfer) begin
               if (last_word) begin
                  wcnt  <= '0;
                  maddr <= maddr + AW'(4) + gap_b;
                  if (last_blk) st <= ST_WB;
                  else begin
                     bcnt <= bcnt + CNT_W'(1);
                     st   <= ST_SRC;
                  end
               end else begin
                  wcnt  <= wcnt + LEN_W'(1);
                  maddr <= maddr + AW'(4);
                  st    <= ST_SRC;
               end
            end
            ST_WB: if (xfer) begin
               if (link_ok) begin
                  base <= {link_ptr, 2'b00};
                  widx <= '0;
                  st   <= ST_FETCH;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R12
   AST_PP_HELD: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (pp_req && !pp_ack) |=> (pp_req && $stable(pp_addr) && $stable(pp_we) && $stable(pp_wdata)));  // R12
   AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SRC && $past(st) == ST_FETCH) |-> ($past(widx) == IDX_LAST));  // R3
endmodule

// File: rtl/chain_dma.sv
module chain_dma
   import cdma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LEN_W      = 16,
   parameter int CNT_W      = 16,
   parameter bit STEP_WORDS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [31:0]   ctl_wdata,
   input  logic          pend_clr,
   output logic          irq,
   output logic          irq_pending,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          pp_req,
   output logic          pp_we,
   output logic [AW-1:0] pp_addr,
   output logic [31:0]   pp_wdata,
   input  logic          pp_ack,
   input  logic [31:0]   pp_rdata
);
   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("chain_dma: AW must lie in 8..32");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("chain_dma: LEN_W must lie in 1..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("chain_dma: CNT_W must lie in 1..32");
      end
   endgenerate

   logic          run, go_new, flush, ctx_live, desc_done;
   logic [AW-1:0] first_addr;

   cdma_cmd #(.AW(AW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctx_live(ctx_live), .run(run), .go_new(go_new), .flush(flush),
      .first_addr(first_addr)
   );

   cdma_seq #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W), .STEP_WORDS(STEP_WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .go_new(go_new), .flush(flush),
      .first_addr(first_addr), .ctx_live(ctx_live), .desc_done(desc_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pp_req(pp_req), .pp_we(pp_we), .pp_addr(pp_addr), .pp_wdata(pp_wdata),
      .pp_ack(pp_ack), .pp_rdata(pp_rdata)
   );

   cdma_irq u_irq (
      .clk(clk), .rst_n(rst_n), .done(desc_done), .clr(pend_clr),
      .irq(irq), .pending(irq_pending)
   );

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[CTL_STOP_BIT] && !mem_req && !pp_req) |=> (!mem_req && !pp_req));  // R10
   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(!rst_n) |-> (!mem_req && !pp_req && !irq));  // R1
endmodule

// File: tb/test_chain_dma.sv
`timescale 1ns/1ps
module test_chain_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we, pend_clr, mem_ack, pp_ack;
   logic [31:0] ctl_wdata, mem_rdata, pp_rdata;
   logic        irq, irq_pending, mem_req, mem_we, pp_req, pp_we;
   logic [31:0] mem_addr, mem_wdata, pp_addr, pp_wdata;

   always #2.5 clk = ~clk;

   chain_dma i_chain_dma (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .pend_clr(pend_clr), .irq(irq), .irq_pending(irq_pending),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pp_req(pp_req), .pp_we(pp_we), .pp_addr(pp_addr), .pp_wdata(pp_wdata),
      .pp_ack(pp_ack), .pp_rdata(pp_rdata)
   );

   logic [31:0] mem    [0:1023];
   logic [31:0] em     [0:1023];
   logic [31:0] exp_pw [0:1023];
   logic [31:0] exp_pa [0:1023];
   logic [31:0] pw_log [0:1023];
   logic [31:0] pw_adr [0:1023];
   logic [31:0] rd_adr [0:15];
   int pw_n = 0, rd_n = 0, pr_cnt = 0, pp_evt = 0, snap_pp = -1, irq_cnt = 0;
   int coll_fail = 0, one_port_fail = 0, n_chk = 0, n_fail = 0;
   int exp_pn = 0, exp_irq = 0, epc = 0;

   function automatic logic [31:0] periph_val(input logic [31:0] a, input int c);
      return {a[7:0], 8'h5A, 16'(c)};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv,
                      input string what);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // bus responders and monitors
   initial begin
      mem_ack = 1'b0; pp_ack = 1'b0; mem_rdata = '0; pp_rdata = '0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         pp_ack  = 1'b0;
         if (mem_req && pp_req) one_port_fail++;
         if (irq) begin
            irq_cnt++;
            if (!irq_pending) coll_fail++;
         end
         if (mem_req && ($urandom % 4 != 0)) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            else begin
               mem_rdata = mem[mem_addr[11:2]];
               if (rd_n < 16) rd_adr[rd_n] = mem_addr;
               rd_n++;
               if (rd_n == 12) snap_pp = pp_evt;
            end
         end
         if (pp_req && ($urandom % 4 != 0)) begin
            pp_ack = 1'b1;
            pp_evt++;
            if (pp_we) begin
               if (pw_n < 1024) begin
                  pw_log[pw_n] = pp_wdata;
                  pw_adr[pw_n] = pp_addr;
               end
               pw_n++;
            end else begin
               pp_rdata = periph_val(pp_addr, pr_cnt);
               pr_cnt++;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(negedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic ctl_write(input logic [31:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0; ctl_wdata = '0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 30) begin
         @(negedge clk);
         q = (mem_req || pp_req) ? 0 : q + 1;
      end
   endtask

   task automatic put_desc(input int w, input logic [31:0] lk, input logic [31:0] ma,
                           input logic [31:0] pa, input logic [31:0] ln, input logic [31:0] gp,
                           input logic [31:0] ct, input logic [31:0] cm);
      mem[w] = lk; mem[w+1] = ma; mem[w+2] = pa; mem[w+3] = ln;
      mem[w+4] = gp; mem[w+5] = ct; mem[w+6] = cm; mem[w+7] = 32'hDEAD_0000;
      for (int i = 8; i < 12; i++) mem[w+i] = $urandom;
   endtask

   // reference walk over a copy of memory, for chains without loops
   task automatic ref_run(input int bw);
      int b = bw;
      exp_pn = 0; exp_irq = 0;
      for (int g = 0; g < 8; g++) begin
         logic [31:0] lk, ma, pa, ln, gp, ct, cm;
         lk = em[b]; ma = em[b+1]; pa = em[b+2]; ln = em[b+3];
         gp = em[b+4]; ct = em[b+5]; cm = em[b+6];
         if (ln != 0 && ct != 0) begin
            for (int k = 0; k < int'(ct); k++) begin
               for (int j = 0; j < int'(ln); j++) begin
                  if (cm[12]) begin
                     exp_pw[exp_pn] = em[ma[11:2]];
                     exp_pa[exp_pn] = pa;
                     exp_pn++;
                  end else begin
                     em[ma[11:2]] = periph_val(pa, epc);
                     epc++;
                  end
                  ma = ma + 4;
               end
               ma = ma + gp * 4;
            end
         end
         em[b+7] = 32'h1;
         if (cm[1]) exp_irq++;
         if (lk[0]) b = int'(lk[11:2]);
         else break;
      end
   endtask

   task automatic do_run(input logic [31:0] base);
      int bad;
      for (int i = 0; i < 1024; i++) em[i] = mem[i];
      epc = pr_cnt; pw_n = 0; rd_n = 0; irq_cnt = 0; coll_fail = 0; snap_pp = -1;
      ref_run(int'(base[11:2]));
      ctl_write(32'h0);
      pp_evt = 0;
      ctl_write(base | 32'h9);
      wait_quiet();
      chk("R4", pw_n, exp_pn, "peripheral write count");
      bad = 0;
      for (int i = 0; i < exp_pn && i < 1024; i++)
         if (pw_log[i] !== exp_pw[i] || pw_adr[i] !== exp_pa[i]) bad++;
      chk("R4", bad, 0, "peripheral write data/address mismatches");
      bad = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== em[i]) bad++;
      chk("R5", bad, 0, "memory image mismatches (data and status words)");
      chk("R8", irq_cnt, exp_irq, "interrupt pulse count");
      chk("R12", one_port_fail, 0, "cycles with both ports requested");
   endtask

   task automatic gen_chain();
      int nd = 1 + int'($urandom % 3);
      for (int k = 0; k < nd; k++) begin
         int w = 128 + 16 * k;
         logic [31:0] cm = (($urandom % 2) != 0 ? 32'h1000 : 32'h0) |
                           (($urandom % 2) != 0 ? 32'h2 : 32'h0);
         logic [31:0] lk = (k == nd - 1) ? ($urandom & 32'hFFFF_FFFE)
                                         : (32'((w + 16) * 4) | 32'h1);
         logic [31:0] ma = cm[12] ? 32'((256 + 32 * k) * 4) : 32'((512 + 32 * k) * 4);
         put_desc(w, lk, ma, 32'h9000_0000 | 32'(k << 4), $urandom % 5, $urandom % 3,
                  $urandom % 4, cm);
      end
   endtask

   initial begin
      int seed_init;
      int bad;
      int base_irq;
      int base_pw;
      logic [31:0] pat [0:3];
      seed_init = $urandom(32'd2024);
      ctl_we = 1'b0; ctl_wdata = '0; pend_clr = 1'b0;
      for (int i = 0; i < 1024; i++) mem[i] = 32'hC000_0000 | 32'(i * 7);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {30'b0, mem_req, pp_req}, 32'h0, "requests after reset");
      chk("R1", {30'b0, irq, irq_pending}, 32'h0, "interrupt state after reset");

      // ring of two descriptors, memory to peripheral
      put_desc(0,  32'h41, 32'h400, 32'h8000_0030, 2, 0, 1, 32'h1002);
      put_desc(16, 32'h01, 32'h410, 32'h8000_0030, 2, 0, 1, 32'h1002);
      pat[0] = mem[256]; pat[1] = mem[257]; pat[2] = mem[260]; pat[3] = mem[261];
      pw_n = 0; irq_cnt = 0;
      ctl_write(32'h0);
      ctl_write(32'h0000_0009);
      while (irq_cnt < 5) @(negedge clk);
      ctl_write(32'h0000_0011);
      repeat (10) @(negedge clk);
      base_irq = irq_cnt; base_pw = pw_n; bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (mem_req || pp_req) bad++;
      end
      chk("R10", bad, 0, "requests while stopped");
      chk("R10", pw_n, base_pw, "peripheral writes while stopped");
      chk("R10", irq_cnt, base_irq, "interrupts while stopped");
      ctl_write(32'h0000_0109);             // resume, address ignored
      while (irq_cnt < base_irq + 4) @(negedge clk);
      ctl_write(32'h0000_0308);             // start while running: ignored
      base_irq = irq_cnt;
      while (irq_cnt < base_irq + 4) @(negedge clk);
      ctl_write(32'h0000_0010);
      wait_quiet();
      bad = 0;
      for (int i = 0; i < pw_n && i < 1024; i++)
         if (pw_log[i] !== pat[i % 4] || pw_adr[i] !== 32'h8000_0030) bad++;
      chk("R9", bad, 0, "ring stream order across stop/resume/ignored start");
      chk("R10", (pw_n >= 24) ? 32'h1 : 32'h0, 32'h1, "ring made progress after resume");
      chk("R7", mem[7], 32'h1, "status word of first ring descriptor");
      chk("R7", mem[23], 32'h1, "status word of second ring descriptor");

      // directed linear chain after a clearing write
      put_desc(64, 32'h141, 32'h400, 32'h8000_0010, 3, 1, 2, 32'h1002);
      put_desc(80, 32'h181, 32'h0,   32'h8000_0010, 0, 0, 5, 32'h1002);
      put_desc(96, 32'h0,   32'h800, 32'h8000_0020, 2, 2, 2, 32'h0);
      do_run(32'h100);
      chk("R11", rd_adr[0], 32'h100, "first fetch address after clear");
      bad = 0;
      for (int i = 0; i < 12; i++) if (rd_adr[i] !== 32'h100 + 32'(4 * i)) bad++;
      chk("R2", bad, 0, "descriptor fetch address sequence");
      chk("R3", snap_pp, 0, "peripheral accesses before twelfth fetch read");
      chk("R4", exp_pn, 6, "expected memory-to-peripheral word count");
      chk("R4", pw_log[3], mem[260], "gap applied after first block");
      chk("R5", mem[516], periph_val(32'h8000_0020, epc - 2), "gap applied in peripheral-to-memory");
      chk("R6", mem[87], 32'h1, "zero-length descriptor status");
      chk("R6", irq_cnt, 2, "zero-length descriptor interrupt");
      chk("R9", mem[103], 32'h1, "third descriptor reached through links");
      chk("R8", {31'b0, irq_pending}, 32'h1, "pending held after completion");
      @(negedge clk); pend_clr = 1'b1;
      @(negedge clk); pend_clr = 1'b0;
      chk("R8", {31'b0, irq_pending}, 32'h0, "pending cleared");

      // random chains; alternate runs hold the clear input high
      for (int it = 0; it < 6; it++) begin
         gen_chain();
         @(negedge clk); pend_clr = (it % 2) != 0;
         do_run(32'h200);
         chk("R8", coll_fail, 0, "pending low during an interrupt pulse");
         chk("R8", {31'b0, irq_pending},
             ((it % 2) == 0 && exp_irq > 0) ? 32'h1 : 32'h0, "pending after run");
         @(negedge clk); pend_clr = 1'b1;
         @(negedge clk); pend_clr = 1'b0;
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule